// File: doc/BRIEF.md
# Multicast Source-Route Circuit Switch Core

This block is the routing core of an eight-link wormhole switch whose packets carry their own path. Every input watches for a header flit. It reads the route tag at the low end of that header and works out which outputs the packet wants. A tag can name one output. It can also name a run of neighbouring outputs, and in that case the packet is copied to all of them at once. The wanted outputs are held as a circuit. The header goes out with the tag removed, then the body flits follow unchanged. The circuit stays up until the flit that carries the end-of-packet mark has passed.

The outputs of a circuit move in lockstep. A flit leaves the input only when every output it is bound to can take it, and no copy is buffered per branch. Headers that ask for outputs already in use wait at their inputs. A waiting header keeps the outputs it asked for away from later-ranked inputs. A wide multicast therefore cannot be starved by narrow packets that slip into parts of its range.

Top module: `srmc_router`

## Requirements
- R1: During reset and after it, with no header offered, every out_valid and every in_ready is low.
- R2: The header tag uses these bits: bit 3 is the multicast flag, bits 2:0 are the base port and bits 6:4 are the upper port. Each router removes seven bits, so the header it sends on equals the received header shifted right by 7 with zeros filling from the top.
- R3: A header whose bit 3 is clear reserves only the base output.
- R4: A header whose bit 3 is set reserves every output from base up to upper, both ends included. If upper is below base, only the base output is reserved.
- R5: A flit leaves its input (in_ready high) only in a cycle in which every reserved output has out_ready high. In any other cycle, no output of that circuit shows out_valid.
- R6: Body flits reach every reserved output with their data unchanged, and each copy carries the end-of-packet mark of the input flit.
- R7: An output is free again in the cycle after it forwards the end-of-packet flit. The header of a waiting packet is then granted at the next edge and shows on the outputs one cycle after the release.
- R8: A header whose requested range touches an output already held is stalled as a whole. None of its outputs shows its flits until the whole range is free, and no output is ever held by two circuits.
- R9: Among headers waiting in the same cycle, the lowest-numbered input goes first. The outputs wanted by a waiting header are withheld from all higher-numbered inputs, even while the waiting header itself cannot yet be granted.
- R10: Circuits whose output sets do not overlap run at the same time.
- R11: The circuit forms one clock edge after the header appears. The header is visible on the outputs in the cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 8 | One flit-present flag per input |
| in_data | input | 128 | 16-bit flit per input, input k at bits 16k+15:16k |
| in_eop | input | 8 | End-of-packet mark per input flit |
| in_ready | output | 8 | Flit taken from the input this cycle |
| out_valid | output | 8 | Flit offered on each output |
| out_data | output | 128 | 16-bit flit per output, output k at bits 16k+15:16k |
| out_eop | output | 8 | End-of-packet mark per output flit |
| out_ready | input | 8 | Downstream link can take a flit |

## Verification
The bench sweeps every one of the 128 tag encodings from a single input. For each one it compares the set of lit outputs with a mask computed in the bench, so an off-by-one on either end of the range would show up. So would an inverted empty-range rule, or a tag shift of the wrong width. It stalls one branch of a multicast to show that no copy leaks to the ready branches. A design that replicates per branch would instead fire the ready outputs early. It checks the exact cycle in which a blocked header takes freed outputs. A release one cycle late or early shows as a missing or premature header. It also checks that a waiting wide multicast blocks a later unicast into its range. A greedy per-output grant would let the unicast in first.

// File: rtl/srmc_pkg.sv
package srmc_pkg;

  // Per-input circuit phase: idle, waiting to pass header, passing body.
  typedef enum logic [1:0] {
    CIRC_IDLE = 2'd0,
    CIRC_HEAD = 2'd1,
    CIRC_BODY = 2'd2
  } circ_state_e;

endpackage

// File: rtl/srmc_tag_decode.sv
module srmc_tag_decode #(
  parameter int NPORTS = 8,
  parameter int FLIT_W = 16
) (
  input  logic [FLIT_W-1:0] hdr,
  output logic [NPORTS-1:0] port_mask,
  output logic [FLIT_W-1:0] hdr_fwd
);
  localparam int PORT_W  = $clog2(NPORTS);
  localparam int ROUTE_W = 1 + 2 * PORT_W;

  logic [PORT_W-1:0] base_port;
  logic [PORT_W-1:0] upper_port;
  logic              mcast;

  assign base_port  = hdr[PORT_W-1:0];
  assign mcast      = hdr[PORT_W];
  assign upper_port = hdr[PORT_W+1 +: PORT_W];

  // An empty range (upper below base) falls back to the base port alone.
  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    localparam logic [PORT_W-1:0] PIDX = PORT_W'(p);
    logic in_range;
    assign in_range     = (PIDX >= base_port) && (PIDX <= upper_port);
    assign port_mask[p] = (PIDX == base_port) || (mcast && in_range);
  end

  assign hdr_fwd = hdr >> ROUTE_W;
endmodule

// File: rtl/srmc_claim_arb.sv
module srmc_claim_arb #(
  parameter int NPORTS = 8
) (
  input  logic [NPORTS-1:0]        req,
  input  logic [NPORTS*NPORTS-1:0] req_mask,
  input  logic [NPORTS-1:0]        busy,
  output logic [NPORTS-1:0]        grant
);
  // Index order: each waiting request shadows its range from later inputs.
  always_comb begin
    logic [NPORTS-1:0] shadow;
    shadow = '0;
    for (int i = 0; i < NPORTS; i++) begin
      grant[i] = req[i] &&
                 ((req_mask[i*NPORTS +: NPORTS] & (busy | shadow)) == '0);
      if (req[i]) shadow = shadow | req_mask[i*NPORTS +: NPORTS];
    end
  end
endmodule

// File: rtl/srmc_circuit.sv
module srmc_circuit
  import srmc_pkg::*;
#(
  parameter int NPORTS = 8,
  parameter int FLIT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [FLIT_W-1:0] in_data,
  input  logic              in_eop,
  input  logic              grant,
  input  logic [NPORTS-1:0] req_mask,
  input  logic [FLIT_W-1:0] hdr_fwd,
  input  logic [NPORTS-1:0] out_ready,
  output logic              in_ready,
  output logic              active,
  output logic              waiting,
  output logic [NPORTS-1:0] held_mask,
  output logic              fwd_valid,
  output logic [FLIT_W-1:0] fwd_data
);
  circ_state_e       st_q, st_d;
  logic [NPORTS-1:0] mask_q, mask_d;
  logic              mask_en;
  logic              all_rdy;
  logic              fire;

  assign active    = (st_q != CIRC_IDLE);
  assign waiting   = (st_q == CIRC_IDLE) && in_valid;
  assign held_mask = active ? mask_q : '0;
  assign all_rdy   = &(out_ready | ~mask_q);
  assign fire      = active && in_valid && all_rdy;
  assign in_ready  = active && all_rdy;
  assign fwd_valid = fire;
  assign fwd_data  = (st_q == CIRC_HEAD) ? hdr_fwd : in_data;

  always_comb begin
    st_d    = st_q;
    mask_d  = mask_q;
    mask_en = 1'b0;
    unique case (st_q)
      CIRC_IDLE: begin
        if (grant) begin
          st_d    = CIRC_HEAD;
          mask_d  = req_mask;
          mask_en = 1'b1;
        end
      end
      CIRC_HEAD, CIRC_BODY: begin
        if (fire) st_d = in_eop ? CIRC_IDLE : CIRC_BODY;
      end
      default: st_d = CIRC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= CIRC_IDLE;
      mask_q <= '0;
    end else begin
      st_q <= st_d;
      if (mask_en) mask_q <= mask_d;
    end
  end
endmodule

// File: rtl/srmc_router.sv
module srmc_router #(
  parameter int NPORTS = 8,
  parameter int FLIT_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NPORTS-1:0]        in_valid,
  input  logic [NPORTS*FLIT_W-1:0] in_data,
  input  logic [NPORTS-1:0]        in_eop,
  output logic [NPORTS-1:0]        in_ready,
  output logic [NPORTS-1:0]        out_valid,
  output logic [NPORTS*FLIT_W-1:0] out_data,
  output logic [NPORTS-1:0]        out_eop,
  input  logic [NPORTS-1:0]        out_ready
);
  localparam int MASK_BITS = NPORTS * NPORTS;

  // Reset: asserted at once, removed on a clock edge.
  logic rst_meta_n, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  logic [MASK_BITS-1:0] req_mask_flat;
  logic [MASK_BITS-1:0] held_flat;
  logic [NPORTS-1:0]    circ_active;
  logic [NPORTS-1:0]    circ_wait;
  logic [NPORTS-1:0]    grant;
  logic [NPORTS-1:0]    fwd_valid;
  logic [FLIT_W-1:0]    fwd_data [NPORTS];
  logic [NPORTS-1:0]    busy;

  for (genvar i = 0; i < NPORTS; i++) begin : g_in
    logic [FLIT_W-1:0] hdr_fwd;

    srmc_tag_decode #(.NPORTS(NPORTS), .FLIT_W(FLIT_W)) u_dec (
      .hdr       (in_data[i*FLIT_W +: FLIT_W]),
      .port_mask (req_mask_flat[i*NPORTS +: NPORTS]),
      .hdr_fwd   (hdr_fwd)
    );

    srmc_circuit #(.NPORTS(NPORTS), .FLIT_W(FLIT_W)) u_circ (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .in_valid  (in_valid[i]),
      .in_data   (in_data[i*FLIT_W +: FLIT_W]),
      .in_eop    (in_eop[i]),
      .grant     (grant[i]),
      .req_mask  (req_mask_flat[i*NPORTS +: NPORTS]),
      .hdr_fwd   (hdr_fwd),
      .out_ready (out_ready),
      .in_ready  (in_ready[i]),
      .active    (circ_active[i]),
      .waiting   (circ_wait[i]),
      .held_mask (held_flat[i*NPORTS +: NPORTS]),
      .fwd_valid (fwd_valid[i]),
      .fwd_data  (fwd_data[i])
    );
  end

  always_comb begin
    busy = '0;
    for (int i = 0; i < NPORTS; i++) busy = busy | held_flat[i*NPORTS +: NPORTS];
  end

  srmc_claim_arb #(.NPORTS(NPORTS)) u_arb (
    .req      (circ_wait),
    .req_mask (req_mask_flat),
    .busy     (busy),
    .grant    (grant)
  );

  // Output crossbar: each output copies the one circuit that holds it.
  always_comb begin
    out_valid = '0;
    out_eop   = '0;
    out_data  = '0;
    for (int o = 0; o < NPORTS; o++) begin
      for (int i = 0; i < NPORTS; i++) begin
        if (held_flat[i*NPORTS + o]) begin
          out_valid[o]                  = out_valid[o] | fwd_valid[i];
          out_eop[o]                    = out_eop[o] | in_eop[i];
          out_data[o*FLIT_W +: FLIT_W] = out_data[o*FLIT_W +: FLIT_W] | fwd_data[i];
        end
      end
    end
  end
endmodule

// File: rtl/srmc_router_chk.sv
module srmc_router_chk #(
  parameter int NPORTS = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [NPORTS-1:0]        in_valid,
  input logic [NPORTS-1:0]        in_ready,
  input logic [NPORTS-1:0]        in_eop,
  input logic [NPORTS-1:0]        out_valid,
  input logic [NPORTS-1:0]        circ_active,
  input logic [NPORTS*NPORTS-1:0] held_flat
);
  logic [NPORTS-1:0] owner_col [NPORTS];
  logic [NPORTS-1:0] held_any;

  always_comb begin
    held_any = '0;
    for (int o = 0; o < NPORTS; o++) begin
      for (int i = 0; i < NPORTS; i++) owner_col[o][i] = held_flat[i*NPORTS + o];
    end
    for (int i = 0; i < NPORTS; i++) held_any = held_any | held_flat[i*NPORTS +: NPORTS];
  end

  for (genvar o = 0; o < NPORTS; o++) begin : g_out
    assert_single_owner_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(owner_col[o]));
  end

  for (genvar i = 0; i < NPORTS; i++) begin : g_in
    assert_lockstep_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid[i] && in_ready[i]) |->
        ((held_flat[i*NPORTS +: NPORTS] & out_valid) == held_flat[i*NPORTS +: NPORTS]));

    assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid[i] && in_ready[i] && in_eop[i]) |=> !circ_active[i]);

    assert_claim_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(circ_active[i]) |->
        ((held_flat[i*NPORTS +: NPORTS] & $past(held_any)) == '0));

    assert_range_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (circ_active[i] && $past(circ_active[i])) |->
        $stable(held_flat[i*NPORTS +: NPORTS]));

    assert_idle_no_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(circ_active[i]) |-> !$past(in_ready[i]));
  end
endmodule

bind srmc_router srmc_router_chk #(.NPORTS(NPORTS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_eop      (in_eop),
  .out_valid   (out_valid),
  .circ_active (circ_active),
  .held_flat   (held_flat)
);

// File: tb/srmc_router_tb.sv
`timescale 1ns/1ps
module srmc_router_tb;
  localparam int N = 8;
  localparam int W = 16;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [N-1:0]   in_valid, in_eop, out_ready;
  logic [N*W-1:0] in_data;
  logic [N-1:0]   in_ready, out_valid, out_eop;
  logic [N*W-1:0] out_data;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  srmc_router #(.NPORTS(N), .FLIT_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_eop(in_eop), .in_ready(in_ready), .out_valid(out_valid),
    .out_data(out_data), .out_eop(out_eop), .out_ready(out_ready)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [N-1:0] exp_mask(input logic [W-1:0] h);
    logic [N-1:0] m;
    for (int p = 0; p < N; p++)
      m[p] = (p == int'(h[2:0])) ||
             (h[3] && p >= int'(h[2:0]) && p <= int'(h[6:4]));
    return m;
  endfunction

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic drv(input int i, input bit v, input logic [W-1:0] d, input bit e);
    in_valid[i]        = v;
    in_data[i*W +: W]  = d;
    in_eop[i]          = e;
  endtask

  task automatic chk_outs(input string tag, input logic [N-1:0] m,
                          input logic [W-1:0] d, input bit e);
    #1;
    chk(out_valid == m, {tag, " out_valid"}, 32'(out_valid), 32'(m));
    for (int o = 0; o < N; o++) begin
      if (m[o]) begin
        chk(out_data[o*W +: W] == d, {tag, " out_data"}, 32'(out_data[o*W +: W]), 32'(d));
        chk(out_eop[o] == e, {tag, " out_eop"}, 32'(out_eop[o]), 32'(e));
      end
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] h, h2, h4;
    rst_n     = 1'b0;
    in_valid  = '0;
    in_eop    = '0;
    in_data   = '0;
    out_ready = '1;
    repeat (3) @(posedge clk);
    #2;
    // R1: held in reset
    chk(out_valid == 0 && in_ready == 0, "R1 in reset", 32'({in_ready, out_valid}), 0);
    rst_n = 1'b1;
    repeat (4) tick();
    chk(out_valid == 0 && in_ready == 0, "R1 after reset", 32'({in_ready, out_valid}), 0);

    // R2 R3 R4 R6 R7 R11: full tag sweep from input 0
    for (int idx = 0; idx < 128; idx++) begin
      h = {9'(idx * 37 + 5), 7'(idx)};
      drv(0, 1, h, 0);
      #1;
      chk(out_valid == 0, "R11 before edge", 32'(out_valid), 0);
      tick();
      chk_outs("R2 R3 R4 header", exp_mask(h), h >> 7, 1'b0);
      chk(in_ready[0] == 1'b1, "R11 header ready", 32'(in_ready[0]), 1);
      tick();
      drv(0, 1, h ^ 16'h5A5A, 1);
      chk_outs("R6 body eop", exp_mask(h), h ^ 16'h5A5A, 1'b1);
      tick();
      drv(0, 0, '0, 0);
      #1;
      chk(out_valid == 0 && in_ready == 0, "R7 released", 32'({in_ready, out_valid}), 0);
    end

    // R5: one stalled branch freezes the multicast
    h = 16'hC300 | 16'h005A;             // ports 2..5
    drv(1, 1, h, 0);
    tick();
    out_ready[3] = 1'b0;
    #1;
    chk(out_valid == 0, "R5 stalled outs", 32'(out_valid), 0);
    chk(in_ready[1] == 1'b0, "R5 stalled input", 32'(in_ready[1]), 0);
    tick();
    chk(out_valid == 0, "R5 still stalled", 32'(out_valid), 0);
    out_ready[3] = 1'b1;
    chk_outs("R5 resumed", 8'h3C, h >> 7, 1'b0);
    tick();
    drv(1, 1, 16'h1234, 1);
    chk_outs("R5 body", 8'h3C, 16'h1234, 1'b1);
    tick();
    drv(1, 0, '0, 0);

    // R8 R7: blocked multicast waits for a held port in its range
    drv(0, 1, 16'h0004, 0);              // unicast port 4
    tick();
    tick();                               // header forwarded
    drv(0, 0, '0, 0);
    h2 = 16'hAB80 | 16'h005B;             // multicast ports 3..5
    drv(2, 1, h2, 0);
    tick();
    #1;
    chk(out_valid == 0 && in_ready[2] == 0, "R8 stalled whole",
        32'({in_ready[2], out_valid}), 0);
    tick();
    drv(0, 1, 16'h0BAD, 1);
    chk_outs("R8 no partial", 8'h10, 16'h0BAD, 1'b1);
    tick();                               // eop forwarded
    drv(0, 0, '0, 0);
    chk_outs("R7 free cycle", 8'h00, '0, 1'b0);
    tick();                               // waiting header granted
    chk_outs("R7 regrant", 8'h38, h2 >> 7, 1'b0);
    tick();
    drv(2, 1, 16'h7777, 1);
    tick();
    drv(2, 0, '0, 0);

    // R9: lowest input wins a shared port
    h  = 16'h4E00 | 16'h007E;             // input 3 wants ports 6..7
    h4 = 16'h9900 | 16'h0006;             // input 5 wants port 6
    drv(3, 1, h, 0);
    drv(5, 1, h4, 0);
    tick();
    chk_outs("R9 low index wins", 8'hC0, h >> 7, 1'b0);
    chk(in_ready[5] == 1'b0, "R9 loser waits", 32'(in_ready[5]), 0);
    tick();
    drv(3, 1, 16'h2222, 1);
    tick();
    drv(3, 0, '0, 0);
    chk_outs("R9 free cycle", 8'h00, '0, 1'b0);
    tick();
    chk_outs("R9 loser served", 8'h40, h4 >> 7, 1'b0);
    tick();
    drv(5, 1, 16'h3333, 1);
    tick();
    drv(5, 0, '0, 0);

    // R9: a waiting range is withheld from higher inputs
    drv(1, 1, 16'h1200, 0);               // port 0
    tick();
    tick();
    drv(1, 0, '0, 0);
    h2 = 16'h6600 | 16'h0018;             // input 2 wants ports 0..1
    h4 = 16'h5500 | 16'h0001;             // input 4 wants port 1
    drv(2, 1, h2, 0);
    drv(4, 1, h4, 0);
    tick();
    tick();
    #1;
    chk(out_valid == 0 && in_ready[4] == 0, "R9 shadowed unicast",
        32'({in_ready[4], out_valid}), 0);
    drv(1, 1, 16'h0E0F, 1);
    tick();
    drv(1, 0, '0, 0);
    tick();
    chk_outs("R9 wide first", 8'h03, h2 >> 7, 1'b0);
    tick();
    drv(2, 1, 16'h4444, 1);
    tick();
    drv(2, 0, '0, 0);
    tick();
    chk_outs("R9 unicast after", 8'h02, h4 >> 7, 1'b0);
    tick();
    drv(4, 1, 16'h5555, 1);
    tick();
    drv(4, 0, '0, 0);

    // R10: disjoint circuits in parallel
    drv(6, 1, 16'hF002, 0);               // port 2
    drv(7, 1, 16'h0F07, 0);               // port 7
    tick();
    #1;
    chk(out_valid == 8'h84, "R10 both open", 32'(out_valid), 32'h84);
    chk(out_data[2*W +: W] == (16'hF002 >> 7), "R10 data a",
        32'(out_data[2*W +: W]), 32'(16'hF002 >> 7));
    chk(out_data[7*W +: W] == (16'h0F07 >> 7), "R10 data b",
        32'(out_data[7*W +: W]), 32'(16'h0F07 >> 7));
    tick();
    drv(6, 1, 16'h6666, 1);
    drv(7, 1, 16'h8888, 1);
    tick();
    drv(6, 0, '0, 0);
    drv(7, 0, '0, 0);
    #1;
    chk(out_valid == 0 && in_ready == 0, "R1 idle at end", 32'({in_ready, out_valid}), 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule